// File: doc/BRIEF.md
# Branch and Indirect-Jump Target Resolver

This block sits beside the execute stage of a processor core and settles where control goes after a conditional branch or a register-indirect jump. From the current program counter, the two source operands, the immediate and a condition code, it decides whether the transfer happens. It then produces the target address, the address of the next sequential instruction (the link value), and the program counter to use next. It also flags instruction-address-misaligned faults and reports the address that caused them.

The alignment rule depends on whether the core accepts 16-bit instructions. When it does, any even target is legal. When it does not, a target must sit on a 4-byte boundary. A 32-bit mode on the 64-bit datapath compares operands and produces addresses as sign-extended 32-bit values. Inputs are captured in one register stage and the results in a second one, so every result appears two clock edges after the inputs were sampled.

Top module: `branch_target_unit`

## Requirements
- R1: For an indirect jump (`in_is_jump`=1), `out_taken` is 1 and `out_target` is `in_rs1 + in_imm` with bit 0 cleared.
- R2: With `in_xlen32`=1, comparisons use the sign extension of the low 32 bits of each operand, and `out_target`, `out_next_pc`, `out_link` and `out_fault_addr` are sign-extended from bit 31.
- R3: With `in_has_c`=1, `out_misalign` is never asserted, whatever the target.
- R4: With `in_has_c`=0, an indirect jump whose target has bit 1 set asserts `out_misalign`, and `out_fault_addr` equals that target.
- R5: With `in_has_c`=0, a taken branch with either of `in_imm[1:0]` set asserts `out_misalign` with `out_fault_addr` = `in_pc + in_imm`. A branch that is not taken never asserts it. `out_fault_addr` is 0 whenever `out_misalign` is 0.
- R6: `out_link` is `in_pc + 4` when `in_len_is4`=1 and `in_pc + 2` when it is 0.
- R7: Branch conditions on `in_cond`: 0 equal, 1 not equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than, 7 unsigned greater-or-equal. Codes 2 and 3 are never taken. A branch target is `in_pc + in_imm`.
- R8: `out_next_pc` is the target when the transfer is taken without a fault, and `in_pc` plus the instruction length when it is not taken.
- R9: When `out_misalign` is asserted, `out_next_pc` equals `in_pc`, so the faulting target is not committed.
- R10: Results appear two rising edges after the inputs are sampled, with `out_valid` following `in_valid` by the same delay. Synchronous reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry a transfer to resolve |
| in_is_jump | input | 1 | 1: indirect jump, 0: conditional branch |
| in_cond | input | 3 | Branch condition code |
| in_len_is4 | input | 1 | Current instruction is 4 bytes (else 2) |
| in_has_c | input | 1 | 16-bit instructions are supported |
| in_xlen32 | input | 1 | 32-bit mode on the wide datapath |
| in_pc | input | XLEN | Current program counter |
| in_rs1 | input | XLEN | First source operand / jump base |
| in_rs2 | input | XLEN | Second source operand |
| in_imm | input | XLEN | Sign-extended immediate offset |
| out_valid | output | 1 | Results below are valid |
| out_taken | output | 1 | Transfer is taken |
| out_target | output | XLEN | Computed transfer target |
| out_next_pc | output | XLEN | Program counter to use next |
| out_link | output | XLEN | Address of the next sequential instruction |
| out_misalign | output | 1 | Instruction-address-misaligned fault |
| out_fault_addr | output | XLEN | Target address that caused the fault |

## Verification
The block holds no state beyond its two pipeline stages. A fault in either stage therefore shows at the ports exactly two edges after the affected inputs, as a wrong taken flag, address or fault strobe, and is gone on the next transfer. A corrupted mode or alignment-capability bit in the first stage shows as a fault strobe that is missing or spurious, or as upper address bits that are not sign-extended. A stuck valid bit shows as `out_valid` losing its fixed two-cycle relation to `in_valid`.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_RS2 = 3'd2,
    CMP_RS3 = 3'd3,
    CMP_LT  = 3'd4,
    CMP_GE  = 3'd5,
    CMP_LTU = 3'd6,
    CMP_GEU = 3'd7
  } cmp_code_e;

  localparam int unsigned NARROW_W = 32;
endpackage

// File: rtl/bt_cond_eval.sv
module bt_cond_eval
  import bt_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [2:0]      code,
  input  logic            narrow,
  output logic            take
);
  localparam int unsigned EXT_W = XLEN - NARROW_W;

  logic [XLEN-1:0] a_n, b_n;
  logic            is_eq, is_lt, is_ltu;

  always_comb begin
    a_n = narrow ? {{EXT_W{op_a[NARROW_W-1]}}, op_a[NARROW_W-1:0]} : op_a;
    b_n = narrow ? {{EXT_W{op_b[NARROW_W-1]}}, op_b[NARROW_W-1:0]} : op_b;
    is_eq  = (a_n == b_n);
    is_lt  = ($signed(a_n) < $signed(b_n));
    is_ltu = (a_n < b_n);
    unique case (cmp_code_e'(code))
      CMP_EQ:  take = is_eq;
      CMP_NE:  take = ~is_eq;
      CMP_LT:  take = is_lt;
      CMP_GE:  take = ~is_lt;
      CMP_LTU: take = is_ltu;
      CMP_GEU: take = ~is_ltu;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/bt_addr_gen.sv
module bt_addr_gen
  import bt_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] offset,
  input  logic            is_jump,
  input  logic            len_is4,
  input  logic            narrow,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] seq_pc
);
  localparam int unsigned EXT_W = XLEN - NARROW_W;

  logic [XLEN-1:0] jmp_sum, br_sum, raw_tgt, raw_seq, step;

  always_comb begin
    step    = len_is4 ? XLEN'(4) : XLEN'(2);
    jmp_sum = base + offset;
    br_sum  = pc + offset;
    raw_tgt = is_jump ? {jmp_sum[XLEN-1:1], 1'b0} : br_sum;
    raw_seq = pc + step;
    target  = narrow ? {{EXT_W{raw_tgt[NARROW_W-1]}}, raw_tgt[NARROW_W-1:0]} : raw_tgt;
    seq_pc  = narrow ? {{EXT_W{raw_seq[NARROW_W-1]}}, raw_seq[NARROW_W-1:0]} : raw_seq;
  end
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import bt_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_is_jump,
  input  logic [2:0]      in_cond,
  input  logic            in_len_is4,
  input  logic            in_has_c,
  input  logic            in_xlen32,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  input  logic [XLEN-1:0] in_imm,
  output logic            out_valid,
  output logic            out_taken,
  output logic [XLEN-1:0] out_target,
  output logic [XLEN-1:0] out_next_pc,
  output logic [XLEN-1:0] out_link,
  output logic            out_misalign,
  output logic [XLEN-1:0] out_fault_addr
);
  localparam int unsigned EXT_W = XLEN - NARROW_W;

  // input stage
  logic            s1_valid, s1_jump, s1_len4, s1_has_c, s1_x32;
  logic [2:0]      s1_cond;
  logic [XLEN-1:0] s1_pc, s1_rs1, s1_rs2, s1_imm;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_jump  <= 1'b0;
      s1_len4  <= 1'b0;
      s1_has_c <= 1'b0;
      s1_x32   <= 1'b0;
      s1_cond  <= '0;
      s1_pc    <= '0;
      s1_rs1   <= '0;
      s1_rs2   <= '0;
      s1_imm   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_jump  <= in_is_jump;
      s1_len4  <= in_len_is4;
      s1_has_c <= in_has_c;
      s1_x32   <= in_xlen32;
      s1_cond  <= in_cond;
      s1_pc    <= in_pc;
      s1_rs1   <= in_rs1;
      s1_rs2   <= in_rs2;
      s1_imm   <= in_imm;
    end
  end

  // resolve
  logic            br_take, take, bad_align;
  logic [XLEN-1:0] tgt, seq, cur_pc, nxt, flt;

  bt_cond_eval #(.XLEN(XLEN)) u_cond (
    .op_a   (s1_rs1),
    .op_b   (s1_rs2),
    .code   (s1_cond),
    .narrow (s1_x32),
    .take   (br_take)
  );

  bt_addr_gen #(.XLEN(XLEN)) u_addr (
    .pc      (s1_pc),
    .base    (s1_rs1),
    .offset  (s1_imm),
    .is_jump (s1_jump),
    .len_is4 (s1_len4),
    .narrow  (s1_x32),
    .target  (tgt),
    .seq_pc  (seq)
  );

  always_comb begin
    take   = s1_jump | br_take;
    cur_pc = s1_x32 ? {{EXT_W{s1_pc[NARROW_W-1]}}, s1_pc[NARROW_W-1:0]} : s1_pc;
    if (s1_has_c)
      bad_align = 1'b0;
    else if (s1_jump)
      bad_align = tgt[1];
    else
      bad_align = br_take & (|s1_imm[1:0]);
    if (bad_align)
      nxt = cur_pc;
    else if (take)
      nxt = tgt;
    else
      nxt = seq;
    flt = bad_align ? tgt : '0;
  end

  // output stage
  logic q_jump, q_has_c, q_x32;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_taken      <= 1'b0;
      out_target     <= '0;
      out_next_pc    <= '0;
      out_link       <= '0;
      out_misalign   <= 1'b0;
      out_fault_addr <= '0;
      q_jump         <= 1'b0;
      q_has_c        <= 1'b0;
      q_x32          <= 1'b0;
    end else begin
      out_valid      <= s1_valid;
      out_taken      <= take;
      out_target     <= tgt;
      out_next_pc    <= nxt;
      out_link       <= seq;
      out_misalign   <= bad_align;
      out_fault_addr <= flt;
      q_jump         <= s1_jump;
      q_has_c        <= s1_has_c;
      q_x32          <= s1_x32;
    end
  end

  // checks
  AST_JUMP_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    q_jump |-> out_taken); // R1
  AST_JUMP_EVEN: assert property (@(posedge clk) disable iff (rst)
    q_jump |-> (out_target[0] == 1'b0)); // R1
  AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (rst)
    q_x32 |-> (out_link[XLEN-1:NARROW_W] == {EXT_W{out_link[NARROW_W-1]}})); // R2
  AST_C_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    q_has_c |-> !out_misalign); // R3
  AST_NOT_TAKEN_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    !out_taken |-> !out_misalign); // R5
  AST_FAULT_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    (bad_align && !s1_x32) |=> (out_next_pc == $past(s1_pc))); // R9
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid); // R10
endmodule

// File: tb/branch_target_unit_tb.sv
`timescale 1ns/1ps
module branch_target_unit_tb_top;
  localparam int unsigned XLEN = 64;

  typedef struct packed {
    logic            jmp;
    logic [2:0]      cnd;
    logic            l4;
    logic            hc;
    logic            x32;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] imm;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 64'h1000, 64'd5, 64'd5, 64'h40},
    '{1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 64'h1000, 64'd5, 64'd5, 64'h40},
    '{1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'h80},
    '{1'b0, 3'd6, 1'b1, 1'b0, 1'b0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'h80},
    '{1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'hFFFF_FFFF_FFFF_FF00},
    '{1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'hFFFF_FFFF_FFFF_FF00},
    '{1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 64'h3000, 64'h2001, 64'd0, 64'h10},
    '{1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 64'h3000, 64'h2000, 64'd0, 64'h2},
    '{1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 64'h3000, 64'h2000, 64'd0, 64'h2},
    '{1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 64'h4000, 64'd9, 64'd9, 64'h6},
    '{1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 64'h4000, 64'd9, 64'd9, 64'h6},
    '{1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 64'h5000, 64'd1, 64'd1, 64'h20},
    '{1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 64'h100, 64'h7FFF_FFF0, 64'd0, 64'h20},
    '{1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 64'h6000, 64'd3, 64'd3, 64'h8}
  };

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid, in_is_jump, in_len_is4, in_has_c, in_xlen32;
  logic [2:0]      in_cond;
  logic [XLEN-1:0] in_pc, in_rs1, in_rs2, in_imm;
  logic            out_valid, out_taken, out_misalign;
  logic [XLEN-1:0] out_target, out_next_pc, out_link, out_fault_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  branch_target_unit #(.XLEN(XLEN)) dut_i (
    .clk, .rst, .in_valid, .in_is_jump, .in_cond, .in_len_is4, .in_has_c,
    .in_xlen32, .in_pc, .in_rs1, .in_rs2, .in_imm, .out_valid, .out_taken,
    .out_target, .out_next_pc, .out_link, .out_misalign, .out_fault_addr
  );

  function automatic logic [XLEN-1:0] sx(input logic [XLEN-1:0] v, input logic n);
    return n ? {{32{v[31]}}, v[31:0]} : v;
  endfunction

  // reference model written from the requirements
  logic            e_tk, e_mis;
  logic [XLEN-1:0] e_tgt, e_nxt, e_lnk, e_flt;

  task automatic model(input vec_t v);
    logic [XLEN-1:0] a, b;
    a = sx(v.a, v.x32);
    b = sx(v.b, v.x32);
    if (v.jmp) begin
      e_tk  = 1'b1;
      e_tgt = sx((v.a + v.imm) & ~64'd1, v.x32);
    end else begin
      case (v.cnd)
        3'd0: e_tk = (a == b);
        3'd1: e_tk = (a != b);
        3'd4: e_tk = ($signed(a) < $signed(b));
        3'd5: e_tk = ($signed(a) >= $signed(b));
        3'd6: e_tk = (a < b);
        3'd7: e_tk = (a >= b);
        default: e_tk = 1'b0;
      endcase
      e_tgt = sx(v.pc + v.imm, v.x32);
    end
    e_lnk = sx(v.pc + (v.l4 ? 64'd4 : 64'd2), v.x32);
    e_mis = !v.hc && (v.jmp ? e_tgt[1] : (e_tk && (v.imm[1:0] != 2'b00)));
    e_flt = e_mis ? e_tgt : '0;
    e_nxt = e_mis ? sx(v.pc, v.x32) : (e_tk ? e_tgt : e_lnk);
  endtask

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid   = 1'b1;
    in_is_jump = v.jmp;
    in_cond    = v.cnd;
    in_len_is4 = v.l4;
    in_has_c   = v.hc;
    in_xlen32  = v.x32;
    in_pc      = v.pc;
    in_rs1     = v.a;
    in_rs2     = v.b;
    in_imm     = v.imm;
    @(negedge clk);
    @(negedge clk);
    model(v);
  endtask

  task automatic check_all(input vec_t v);
    apply(v);
    chk("R10 out_valid", 64'(out_valid), 64'd1);
    chk("R7 out_taken", 64'(out_taken), 64'(e_tk));
    chk("R1 out_target", out_target, e_tgt);
    chk("R8 out_next_pc", out_next_pc, e_nxt);
    chk("R6 out_link", out_link, e_lnk);
    chk("R5 out_misalign", 64'(out_misalign), 64'(e_mis));
    chk("R4 out_fault_addr", out_fault_addr, e_flt);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t d;
    rst = 1'b1;
    in_valid = 1'b0; in_is_jump = 1'b0; in_cond = 3'd0; in_len_is4 = 1'b0;
    in_has_c = 1'b0; in_xlen32 = 1'b0;
    in_pc = '0; in_rs1 = '0; in_rs2 = '0; in_imm = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset out_valid", 64'(out_valid), 64'd0);
    chk("R10 reset out_next_pc", out_next_pc, 64'd0);
    chk("R10 reset out_link", out_link, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) check_all(VEC[i]);

    // R9: misaligned jump leaves the current pc as next pc
    d = '{1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 64'h8000, 64'h1236, 64'd0, 64'h0};
    apply(d);
    chk("R9 next_pc on fault", out_next_pc, 64'h8000);
    chk("R4 fault addr", out_fault_addr, 64'h1236);

    // R3: same branch offset with 16-bit support raises nothing
    d = '{1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 64'h4000, 64'd9, 64'd9, 64'h6};
    apply(d);
    chk("R3 no misalign", 64'(out_misalign), 64'd0);
    chk("R3 next_pc is target", out_next_pc, 64'h4006);

    // R2: signed compare on low word in narrow mode, not in wide mode
    d = '{1'b0, 3'd4, 1'b1, 1'b0, 1'b1, 64'h100, 64'h8000_0000, 64'd0, 64'h40};
    apply(d);
    chk("R2 narrow LT taken", 64'(out_taken), 64'd1);
    d.x32 = 1'b0;
    apply(d);
    chk("R2 wide LT not taken", 64'(out_taken), 64'd0);

    // R2: narrow link wraps and sign-extends
    d = '{1'b0, 3'd1, 1'b1, 1'b0, 1'b1, 64'h7FFF_FFFC, 64'd1, 64'd1, 64'h8};
    apply(d);
    chk("R2 narrow link sext", out_link, 64'hFFFF_FFFF_8000_0000);

    // R10: valid drops two edges after in_valid drops
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 valid still high after one edge", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R10 valid low after two edges", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule